// File: doc/BRIEF.md
# Two-Port Memory with Same-Address Arbitration

This block is a 2048 x 8 storage array with two symmetric access ports, called left and right. Each port has its own active-low select, a read/write mode bit, an active-low output enable, an address and separate write and read data buses. Either port may read or write any word at any time. Everything is synchronous to one clock. Writes land at the clock edge. Read data is registered and shows the word as it was before any write in the same cycle.

When both ports are selected on the same address, an arbitration stage picks the port that arrived first. Arrival is the cycle in which a port's select or address last changed. A true tie goes to the left port. The later port sees its active-low busy output go low in the same cycle, and any write it attempts is dropped. The decision holds while the match lasts. A mode input makes each busy pin a plain write-inhibit input instead. A combined collision flag suits use as an interrupt source.

Top module: `dpram_arb`

## Requirements
- R1: A selected port (`*_en_n`=0) with `*_rw`=0 stores `*_wdata` at `*_addr` on the clock edge. With `*_rw`=1 it loads the word at `*_addr` into `*_rdata`, visible after that edge. The loaded value is the content before any write of the same edge.
- R2: `*_standby` is 1 exactly when the port is deselected (`*_en_n`=1). A deselected port never changes memory.
- R3: If either port is deselected, or the two addresses differ, both busy outputs are 1 and `collision` is 0.
- R4: When a match starts and only one port changed its select or address in that cycle, that port is the later arrival. Its busy goes to 0 in that same cycle.
- R5: When both ports change in the cycle a match starts, the right port's busy goes to 0. The two busy outputs are never 0 together.
- R6: The busy decision holds while the match lasts. It ends when the addresses differ or either port deselects.
- R7: In master mode (`master_mode`=1), a write from the port whose busy is 0 is dropped. The winning port's write proceeds. The `*_inhibit_n` inputs are ignored.
- R8: In slave mode (`master_mode`=0), both busy outputs stay at 1 and arbitration blocks no write. A port whose `*_inhibit_n` is 0 has its writes dropped. A port whose `*_inhibit_n` is 1 writes normally.
- R9: `*_rdata_oe` is 1 exactly when the port is selected, in read mode (`*_rw`=1) and `*_oe_n`=0.
- R10: `collision` is the OR of the two internal busy conditions, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1: busy pins are arbitration outputs; 0: inhibit inputs rule |
| l_en_n | input | 1 | Left select, active low |
| l_rw | input | 1 | Left mode, 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left registered read data |
| l_rdata_oe | output | 1 | Left read data valid to drive |
| l_inhibit_n | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n | output | 1 | Left busy, active low |
| l_standby | output | 1 | Left deselected |
| r_en_n | input | 1 | Right select, active low |
| r_rw | input | 1 | Right mode, 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right registered read data |
| r_rdata_oe | output | 1 | Right read data valid to drive |
| r_inhibit_n | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n | output | 1 | Right busy, active low |
| r_standby | output | 1 | Right deselected |
| collision | output | 1 | Either internal busy condition active |

## Verification
Assertions check on every cycle that the two busy conditions never coincide and that both busy pins stay high when there is no enabled match or in slave mode. They also check who loses when a match starts and that the decision persists while the match holds. Only the bench's scenarios can show that a blocked write really left the stored word untouched, that the winner's write lands, and that the read value precedes a same-edge write. The same applies to the inhibit inputs taking over in slave mode.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
   typedef enum logic {
      SIDE_L = 1'b0,
      SIDE_R = 1'b1
   } side_e;
   localparam int NSIDES = 2;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              r_sel,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_busy,
   output logic              r_busy,
   output logic              match
);
   logic [ADDR_W-1:0] l_addr_q, r_addr_q;
   logic              l_sel_q, r_sel_q, match_q;
   logic              l_chg, r_chg, fresh;
   side_e             win_q, win_now;

   initial if (ADDR_W < 1) $fatal(1, "dpram_arbiter: ADDR_W must be positive");

   assign match = l_sel & r_sel & (l_addr == r_addr);
   assign l_chg = (l_sel != l_sel_q) | (l_addr != l_addr_q);
   assign r_chg = (r_sel != r_sel_q) | (r_addr != r_addr_q);
   assign fresh = match & ~match_q;

   // later arrival loses; a tie goes to the left side
   always_comb begin
      win_now = win_q;
      if (fresh) win_now = (l_chg & ~r_chg) ? SIDE_R : SIDE_L;
   end

   assign l_busy = match & (win_now == SIDE_R);
   assign r_busy = match & (win_now == SIDE_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_addr_q <= '0;
         r_addr_q <= '0;
         l_sel_q  <= 1'b0;
         r_sel_q  <= 1'b0;
         match_q  <= 1'b0;
         win_q    <= SIDE_L;
      end else begin
         l_addr_q <= l_addr;
         r_addr_q <= r_addr;
         l_sel_q  <= l_sel;
         r_sel_q  <= r_sel;
         match_q  <= match;
         win_q    <= win_now;
      end
   end

   // R5: never both sides busy
   a_r5_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_busy && r_busy));
   // R5: simultaneous arrival hands the loss to the right side
   a_r5_tie_right: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh && l_chg && r_chg) |-> r_busy);
   // R4: lone mover is the later arrival
   a_r4_late_left: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh && l_chg && !r_chg) |-> l_busy);
   // R6: decision persists while the match lasts
   a_r6_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
      (match && match_q && $past(l_busy)) |-> l_busy);
   a_r6_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
      (match && match_q && $past(r_busy)) |-> r_busy);
endmodule

// File: rtl/dpram_port.sv
module dpram_port (
   input  logic master,
   input  logic en_n,
   input  logic rw,
   input  logic oe_n,
   input  logic arb_busy,
   input  logic inhibit_n,
   output logic sel,
   output logic we,
   output logic re,
   output logic busy_n,
   output logic rdata_oe,
   output logic standby
);
   logic blk;

   assign sel      = ~en_n;
   assign blk      = master ? arb_busy : ~inhibit_n;
   assign we       = sel & ~rw & ~blk;
   assign re       = sel & rw;
   assign busy_n   = master ? ~arb_busy : 1'b1;
   assign rdata_oe = sel & rw & ~oe_n;
   assign standby  = en_n;
endmodule

// File: rtl/dpram_store.sv
module dpram_store
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NSIDES-1:0]              we,
   input  logic [NSIDES-1:0]              re,
   input  logic [NSIDES-1:0][ADDR_W-1:0]  addr,
   input  logic [NSIDES-1:0][DATA_W-1:0]  wdata,
   output logic [NSIDES-1:0][DATA_W-1:0]  rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   initial if (DATA_W < 1) $fatal(1, "dpram_store: DATA_W must be positive");

   logic [DATA_W-1:0] mem [DEPTH];

   // left written last so it prevails when both sides write one word
   always_ff @(posedge clk) begin
      for (int s = NSIDES - 1; s >= 0; s--)
         if (we[s]) mem[addr[s]] <= wdata[s];
   end

   for (genvar s = 0; s < NSIDES; s++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata[s] <= '0;
         else if (re[s]) rdata[s] <= mem[addr[s]];
      end
   end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              l_en_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rdata_oe,
   input  logic              l_inhibit_n,
   output logic              l_busy_n,
   output logic              l_standby,
   input  logic              r_en_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rdata_oe,
   input  logic              r_inhibit_n,
   output logic              r_busy_n,
   output logic              r_standby,
   output logic              collision
);
   initial if (ADDR_W > 16) $fatal(1, "dpram_arb: ADDR_W too large");

   logic [NSIDES-1:0]             en_n_v, rw_v, oe_n_v, inh_v, arb_busy;
   logic [NSIDES-1:0]             sel_v, we_v, re_v, busy_n_v, oe_v, stby_v;
   logic [NSIDES-1:0][ADDR_W-1:0] addr_v;
   logic [NSIDES-1:0][DATA_W-1:0] wdata_v, rdata_v;
   logic                          match;

   assign en_n_v  = {r_en_n, l_en_n};
   assign rw_v    = {r_rw, l_rw};
   assign oe_n_v  = {r_oe_n, l_oe_n};
   assign inh_v   = {r_inhibit_n, l_inhibit_n};
   assign addr_v  = {r_addr, l_addr};
   assign wdata_v = {r_wdata, l_wdata};

   dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .l_sel  (sel_v[SIDE_L]),
      .r_sel  (sel_v[SIDE_R]),
      .l_addr (l_addr),
      .r_addr (r_addr),
      .l_busy (arb_busy[SIDE_L]),
      .r_busy (arb_busy[SIDE_R]),
      .match  (match)
   );

   for (genvar s = 0; s < NSIDES; s++) begin : g_port
      dpram_port u_port (
         .master    (master_mode),
         .en_n      (en_n_v[s]),
         .rw        (rw_v[s]),
         .oe_n      (oe_n_v[s]),
         .arb_busy  (arb_busy[s]),
         .inhibit_n (inh_v[s]),
         .sel       (sel_v[s]),
         .we        (we_v[s]),
         .re        (re_v[s]),
         .busy_n    (busy_n_v[s]),
         .rdata_oe  (oe_v[s]),
         .standby   (stby_v[s])
      );
   end

   dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_v),
      .re    (re_v),
      .addr  (addr_v),
      .wdata (wdata_v),
      .rdata (rdata_v)
   );

   assign l_rdata    = rdata_v[SIDE_L];
   assign r_rdata    = rdata_v[SIDE_R];
   assign l_rdata_oe = oe_v[SIDE_L];
   assign r_rdata_oe = oe_v[SIDE_R];
   assign l_busy_n   = busy_n_v[SIDE_L];
   assign r_busy_n   = busy_n_v[SIDE_R];
   assign l_standby  = stby_v[SIDE_L];
   assign r_standby  = stby_v[SIDE_R];
   assign collision  = |arb_busy;

   // R3: no enabled match means no busy at the pins
   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (l_en_n || r_en_n || (l_addr != r_addr)) |-> (l_busy_n && r_busy_n && !collision));
   // R8: slave mode keeps both busy pins high
   a_r8_slave_high: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> (l_busy_n && r_busy_n));
   // R9: driven read data needs a selected reading port
   a_r9_oe_left: assert property (@(posedge clk) disable iff (!rst_n)
      l_rdata_oe |-> (!l_en_n && l_rw && !l_oe_n));
   a_r9_oe_right: assert property (@(posedge clk) disable iff (!rst_n)
      r_rdata_oe |-> (!r_en_n && r_rw && !r_oe_n));
endmodule

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;
   localparam int DW = 8;

   logic          clk = 1'b0, rst_n = 1'b0, master_mode = 1'b1;
   logic          l_en_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1, l_inhibit_n = 1'b1;
   logic          r_en_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1, r_inhibit_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic          l_rdata_oe, r_rdata_oe, l_busy_n, r_busy_n, l_standby, r_standby, collision;

   int checks = 0, errors = 0, cyc_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpram_arb u_dut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .l_en_n(l_en_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe), .l_inhibit_n(l_inhibit_n),
      .l_busy_n(l_busy_n), .l_standby(l_standby),
      .r_en_n(r_en_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe), .r_inhibit_n(r_inhibit_n),
      .r_busy_n(r_busy_n), .r_standby(r_standby), .collision(collision)
   );

   typedef struct packed {
      logic          len_n;
      logic [AW-1:0] la;
      logic          ren_n;
      logic [AW-1:0] ra;
      logic          mst;
      logic          e_lb;
      logic          e_rb;
      logic          e_col;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 11'd5,  1'b1, 11'd0,  1'b1, 1'b1, 1'b1, 1'b0, 4'd3},
      '{1'b0, 11'd5,  1'b0, 11'd5,  1'b1, 1'b1, 1'b0, 1'b1, 4'd4},
      '{1'b0, 11'd5,  1'b0, 11'd5,  1'b1, 1'b1, 1'b0, 1'b1, 4'd6},
      '{1'b0, 11'd5,  1'b0, 11'd6,  1'b1, 1'b1, 1'b1, 1'b0, 4'd3},
      '{1'b0, 11'd6,  1'b0, 11'd6,  1'b1, 1'b0, 1'b1, 1'b1, 4'd4},
      '{1'b1, 11'd6,  1'b1, 11'd6,  1'b1, 1'b1, 1'b1, 1'b0, 4'd3},
      '{1'b0, 11'd9,  1'b0, 11'd9,  1'b1, 1'b1, 1'b0, 1'b1, 4'd5},
      '{1'b0, 11'd9,  1'b0, 11'd9,  1'b0, 1'b1, 1'b1, 1'b1, 4'd10},
      '{1'b1, 11'd9,  1'b1, 11'd9,  1'b1, 1'b1, 1'b1, 1'b0, 4'd3},
      '{1'b0, 11'd20, 1'b1, 11'd20, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3},
      '{1'b0, 11'd20, 1'b0, 11'd20, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4},
      '{1'b1, 11'd20, 1'b0, 11'd20, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},
      '{1'b0, 11'd20, 1'b0, 11'd20, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; applies inputs over one rising edge
   task automatic cyc(input logic len, input logic lrw, input int la, input int lwd,
                      input logic ren, input logic rrw, input int ra, input int rwd);
      l_en_n = len; l_rw = lrw; l_addr = AW'(la); l_wdata = DW'(lwd);
      r_en_n = ren; r_rw = rrw; r_addr = AW'(ra); r_wdata = DW'(rwd);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      cyc(1'b1, 1'b1, 0, 0, 1'b1, 1'b1, 0, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc_cnt++;
         if (cyc_cnt > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R2, R3, R9)
      chk("R2 reset l_standby", l_standby, 1);
      chk("R2 reset r_standby", r_standby, 1);
      chk("R3 reset busy", {l_busy_n, r_busy_n, collision}, 3'b110);
      chk("R9 reset oe", {l_rdata_oe, r_rdata_oe}, 0);
      chk("R1 reset rdata", {l_rdata, r_rdata}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // arbitration table: reads only, memory untouched
      for (int i = 0; i < NV; i++) begin
         master_mode = TBL[i].mst;
         l_en_n = TBL[i].len_n; l_addr = TBL[i].la; l_rw = 1'b1;
         r_en_n = TBL[i].ren_n; r_addr = TBL[i].ra; r_rw = 1'b1;
         #1;
         chk($sformatf("R%0d row %0d l_busy_n", TBL[i].req, i), l_busy_n, TBL[i].e_lb);
         chk($sformatf("R%0d row %0d r_busy_n", TBL[i].req, i), r_busy_n, TBL[i].e_rb);
         chk($sformatf("R%0d row %0d collision", TBL[i].req, i), collision, TBL[i].e_col);
         @(posedge clk);
         @(negedge clk);
      end
      master_mode = 1'b1;
      idle();

      // R1: independent writes then crossed reads
      cyc(1'b0, 1'b0, 100, 'hA5, 1'b0, 1'b0, 200, 'h3C);
      cyc(1'b0, 1'b1, 200, 0, 1'b0, 1'b1, 100, 0);
      chk("R1 left reads 200", l_rdata, 'h3C);
      chk("R1 right reads 100", r_rdata, 'hA5);

      // R9: output enable combinations, R2 standby
      l_en_n = 1'b0; l_rw = 1'b1; l_oe_n = 1'b0; #1;
      chk("R9 oe on", l_rdata_oe, 1);
      chk("R2 selected standby", l_standby, 0);
      l_oe_n = 1'b1; #1; chk("R9 oe_n high", l_rdata_oe, 0);
      l_oe_n = 1'b0; l_rw = 1'b0; #1; chk("R9 write mode", l_rdata_oe, 0);
      l_rw = 1'b1; l_en_n = 1'b1; #1; chk("R9 deselected", l_rdata_oe, 0);
      l_oe_n = 1'b1;
      @(negedge clk);

      // R2: deselected write has no effect
      cyc(1'b1, 1'b0, 100, 'hEE, 1'b1, 1'b0, 100, 'hEE);
      cyc(1'b0, 1'b1, 100, 0, 1'b1, 1'b1, 0, 0);
      chk("R2 deselected write ignored", l_rdata, 'hA5);
      idle();

      // R7: late right write is dropped
      cyc(1'b0, 1'b0, 300, 'h11, 1'b1, 1'b1, 0, 0);
      cyc(1'b0, 1'b1, 300, 0, 1'b1, 1'b1, 0, 0);
      l_en_n = 1'b0; l_rw = 1'b1; l_addr = 300;
      r_en_n = 1'b0; r_rw = 1'b0; r_addr = 300; r_wdata = 'h22; #1;
      chk("R4 late right busy", r_busy_n, 0);
      chk("R4 winner left free", l_busy_n, 1);
      @(posedge clk); @(negedge clk);
      idle();
      cyc(1'b0, 1'b1, 300, 0, 1'b1, 1'b1, 0, 0);
      chk("R7 blocked write left word", l_rdata, 'h11);
      idle();

      // R7: winner writes during a collision; R1 read-before-write
      cyc(1'b0, 1'b0, 320, 'h44, 1'b1, 1'b1, 0, 0);
      cyc(1'b0, 1'b0, 320, 'h55, 1'b0, 1'b1, 320, 0);
      chk("R1 right reads old word", r_rdata, 'h44);
      idle();
      cyc(1'b0, 1'b1, 320, 0, 1'b1, 1'b1, 0, 0);
      chk("R7 winner write stored", l_rdata, 'h55);
      idle();

      // R7: inhibit inputs ignored in master mode
      l_inhibit_n = 1'b0;
      cyc(1'b0, 1'b0, 420, 'h5A, 1'b1, 1'b1, 0, 0);
      cyc(1'b0, 1'b1, 420, 0, 1'b1, 1'b1, 0, 0);
      chk("R7 master ignores inhibit", l_rdata, 'h5A);
      l_inhibit_n = 1'b1;
      idle();

      // R8: slave mode inhibit
      cyc(1'b1, 1'b1, 0, 0, 1'b0, 1'b0, 400, 'h01);
      master_mode = 1'b0; r_inhibit_n = 1'b0;
      cyc(1'b1, 1'b1, 0, 0, 1'b0, 1'b0, 400, 'h99);
      cyc(1'b1, 1'b1, 0, 0, 1'b0, 1'b1, 400, 0);
      chk("R8 inhibited write dropped", r_rdata, 'h01);
      r_inhibit_n = 1'b1;
      cyc(1'b1, 1'b1, 0, 0, 1'b0, 1'b0, 400, 'h99);
      cyc(1'b1, 1'b1, 0, 0, 1'b0, 1'b1, 400, 0);
      chk("R8 released write stored", r_rdata, 'h99);
      idle();

      // R8, R10: slave collision does not block
      cyc(1'b0, 1'b1, 410, 0, 1'b1, 1'b1, 0, 0);
      l_en_n = 1'b0; l_rw = 1'b1; l_addr = 410;
      r_en_n = 1'b0; r_rw = 1'b0; r_addr = 410; r_wdata = 'h42; #1;
      chk("R10 slave collision flag", collision, 1);
      chk("R8 slave busy pin high", r_busy_n, 1);
      @(posedge clk); @(negedge clk);
      idle();
      cyc(1'b1, 1'b1, 0, 0, 1'b0, 1'b1, 410, 0);
      chk("R8 slave collision write lands", r_rdata, 'h42);
      master_mode = 1'b1;
      idle();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule